// File: doc/BRIEF.md
# Streaming Test-Traffic Generator and Checker

This block is a test-traffic engine for a 128-bit streaming data path. It sits between a DMA stream and a small control register file. It can be used in three ways. It can check packets arriving on its input stream against a fixed pattern. It can generate packets in that same pattern on its output stream. It can also loop incoming packets straight back to the output. Software selects the way it is used with three enable bits. It sets the generated packet length through a length register and reads a sticky mismatch flag from a status register.

Every packet follows one pattern definition, which the generator and the checker share. Bytes 0 and 1 of a packet hold its byte count, least significant byte first. Every later byte holds the packet's 16-bit sequence tag: even byte positions carry the tag's low byte and odd positions carry its high byte. The tag starts at 0 and goes up by one per packet. The generator and the checker each keep their own tag counter.

Both streams use valid/ready handshaking. A beat moves only in a cycle where valid and ready are both high. Once the generator raises valid, it holds the beat unchanged until ready is seen. In loopback, back-pressure from the output passes straight to the input ready. Outside loopback, the input is always ready, so the checker never stalls the sender.

Top module: `stream_traffic_engine`

## Requirements
- R1: After reset the control register (address 0) reads 0, the length register (address 1) reads 64, the status register (address 2) reads 0, the output valid is low and the input ready is high. Control bit 0 enables the checker, bit 1 enables the generator and bit 2 selects loopback, and the bits read back as written.
- R2: The length register is 16 bits wide. Its value sets the byte count of each generated packet. A value below 2 produces 2-byte packets whose length field reads 2.
- R3: A generated packet carries its length, least significant byte first, in bytes 0 and 1. Every other byte holds the tag: the tag's low byte at even byte positions and its high byte at odd positions. Byte n of a beat is on data bits [8n+7:8n], and a beat holds 16 bytes. Every beat except the last has all tkeep bits set. The last beat has tlast set and tkeep set for exactly its valid bytes, from bit 0 upward.
- R4: The generator's tag is 0 for the first packet after enabling. It goes up by one per packet and wraps from 0xFFFF to 0.
- R5: While the output valid is high and ready is low, the generator keeps valid high and keeps tdata, tkeep and tlast unchanged.
- R6: The generator reads the length register only when a packet starts. A write during a packet takes effect from the next packet.
- R7: When the generator enable is cleared, the packet in progress completes (including one already presented), and no further packet starts. The tag restarts at 0 on re-enable.
- R8: With the loopback bit set, input beats appear unchanged on the output and the input ready follows the output ready. The generator's output is suppressed, and the generator resumes its stalled packet intact once loopback is cleared.
- R9: With the checker enabled, every accepted byte whose tkeep bit is set and that sits outside the length field is compared with the expected tag byte. Any difference sets the status flag (address 2, bit 0, also on the mismatch port), which stays set. Bytes whose tkeep bit is clear are ignored.
- R10: With the checker enabled, the number of kept bytes in a packet, counted at tlast, must equal its length field. Otherwise the status flag is set.
- R11: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A mismatch detected in the same cycle as a clearing write leaves the flag set.
- R12: The checker expects tag 0 first and one more per packet. Clearing the checker enable resets the expected tag to 0. Outside loopback the input ready stays high even when the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 length, 2 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| s_tdata | input | 128 | Input stream data |
| s_tkeep | input | 16 | Input stream byte enables |
| s_tlast | input | 1 | Input stream end of packet |
| s_tvalid | input | 1 | Input stream valid |
| s_tready | output | 1 | Input stream ready |
| m_tdata | output | 128 | Output stream data |
| m_tkeep | output | 16 | Output stream byte enables |
| m_tlast | output | 1 | Output stream end of packet |
| m_tvalid | output | 1 | Output stream valid |
| m_tready | input | 1 | Output stream ready |
| mismatch | output | 1 | Sticky checker mismatch flag |

## Verification
The generator is run with packet lengths of 40, 20 and 2 bytes, and with a length write of 0 that must be raised to 2. These lengths separate the full-beat, partial-beat and single-beat tkeep cases. It also runs a length change in mid-packet and a long run of 2-byte packets that crosses the 0xFFFF tag wrap. The checker receives a clean packet, a clean packet with garbage in its unkept lanes, and a single corrupted byte. It also receives a length field that disagrees with the real byte count and a packet that carries a stale tag. Each of these shows whether the flag rises only on the fault meant to trip it. Loopback is driven with a stalled output and with the generator enabled, to show that ready passes through and that generator data stays off the output.

// File: rtl/tge_pkg.sv
package tge_pkg;
  localparam int TAG_W = 16;
  localparam int LEN_W = 16;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL = 2'd0,
    RA_LEN  = 2'd1,
    RA_STAT = 2'd2,
    RA_RSVD = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic loop_en;
    logic gen_en;
    logic chk_en;
  } ctrl_t;
endpackage

// File: rtl/tge_pattern.sv
module tge_pattern
  import tge_pkg::*;
#(
  parameter int NB = 16
) (
  input  logic              first_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [NB*8-1:0]   pat_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign pat_o[8*g +: 8] = (first_i && g < 2) ? len_i[8*(g%2) +: 8]
                                                : tag_i[8*(g%2) +: 8];
  end
endmodule

// File: rtl/tge_gen.sv
module tge_gen
  import tge_pkg::*;
#(
  parameter int NB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [NB*8-1:0]  data_o,
  output logic [NB-1:0]    keep_o,
  output logic             last_o
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);
  localparam logic [LEN_W-1:0] BEAT_B  = LEN_W'(NB);

  logic             active;
  logic             first;
  logic [LEN_W-1:0] remain;
  logic [TAG_W-1:0] tag;
  logic [LEN_W-1:0] eff_len;
  logic             hs;

  assign eff_len = (len_i < MIN_LEN) ? MIN_LEN : len_i;
  assign valid_o = active;
  assign last_o  = (remain <= BEAT_B);
  assign hs      = active && ready_i;

  for (genvar g = 0; g < NB; g++) begin : g_keep
    assign keep_o[g] = (LEN_W'(g) < remain);
  end

  tge_pattern #(.NB(NB)) u_pat (
    .first_i (first),
    .len_i   (remain),
    .tag_i   (tag),
    .pat_o   (data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      first  <= 1'b1;
      remain <= '0;
      tag    <= '0;
    end else if (!active) begin
      if (en_i) begin
        active <= 1'b1;
        first  <= 1'b1;
        remain <= eff_len;
      end else begin
        tag <= '0;
      end
    end else if (hs) begin
      if (last_o) begin
        tag   <= tag + TAG_W'(1);
        first <= 1'b1;
        if (en_i) remain <= eff_len;
        else      active <= 1'b0;
      end else begin
        first  <= 1'b0;
        remain <= remain - BEAT_B;
      end
    end
  end

  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(keep_o) && $stable(last_o)));

  p_keep_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (keep_o != '0 && ((keep_o & (keep_o + NB'(1))) == '0)));

  p_full_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |-> (&keep_o));

  p_tag_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && last_o) |=> (tag == $past(tag) + TAG_W'(1)));
endmodule

// File: rtl/tge_chk.sv
module tge_chk
  import tge_pkg::*;
#(
  parameter int NB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             beat_i,
  input  logic [NB*8-1:0]  data_i,
  input  logic [NB-1:0]    keep_i,
  input  logic             last_i,
  output logic             err_o
);
  localparam int CW = $clog2(NB + 1);

  logic             first;
  logic [TAG_W-1:0] tag;
  logic [LEN_W:0]   cnt;
  logic [LEN_W-1:0] hdr_len;
  logic [NB*8-1:0]  pat;
  logic [NB-1:0]    byte_bad;
  logic [CW-1:0]    beat_bytes;
  logic [LEN_W:0]   total;
  logic [LEN_W-1:0] len_field;
  logic             len_bad;

  tge_pattern #(.NB(NB)) u_pat (
    .first_i (first),
    .len_i   (data_i[LEN_W-1:0]),
    .tag_i   (tag),
    .pat_o   (pat)
  );

  for (genvar g = 0; g < NB; g++) begin : g_cmp
    assign byte_bad[g] = keep_i[g] && (data_i[8*g +: 8] != pat[8*g +: 8]);
  end

  always_comb begin
    beat_bytes = '0;
    for (int i = 0; i < NB; i++) beat_bytes = beat_bytes + CW'(keep_i[i]);
  end

  assign total     = cnt + (LEN_W+1)'(beat_bytes);
  assign len_field = first ? data_i[LEN_W-1:0] : hdr_len;
  assign len_bad   = last_i && (total != {1'b0, len_field});
  assign err_o     = en_i && beat_i && ((|byte_bad) || len_bad);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      first   <= 1'b1;
      tag     <= '0;
      cnt     <= '0;
      hdr_len <= '0;
    end else if (beat_i) begin
      if (first) hdr_len <= data_i[LEN_W-1:0];
      if (last_i) begin
        first <= 1'b1;
        cnt   <= '0;
        tag   <= tag + TAG_W'(1);
      end else begin
        first <= 1'b0;
        cnt   <= total;
      end
    end
  end

  p_tag_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (tag == '0));

  p_tag_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && beat_i && last_i) |=> (tag == $past(tag) + TAG_W'(1)));
endmodule

// File: rtl/tge_regs.sv
module tge_regs
  import tge_pkg::*;
#(
  parameter logic [LEN_W-1:0] LEN_RST = LEN_W'(64)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [LEN_W-1:0]  wdata_i,
  output logic [LEN_W-1:0]  rdata_o,
  input  logic              err_i,
  output ctrl_t             ctrl_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              mism_o
);
  logic clr;
  assign clr = wr_i && (addr_i == RA_STAT) && wdata_i[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_o <= '0;
      len_o  <= LEN_RST;
      mism_o <= 1'b0;
    end else begin
      if (wr_i && addr_i == RA_CTRL) ctrl_o <= ctrl_t'(wdata_i[2:0]);
      if (wr_i && addr_i == RA_LEN)  len_o  <= wdata_i;
      mism_o <= err_i || (mism_o && !clr);
    end
  end

  always_comb begin
    case (addr_i)
      RA_CTRL: rdata_o = LEN_W'(ctrl_o);
      RA_LEN:  rdata_o = len_o;
      RA_STAT: rdata_o = LEN_W'(mism_o);
      default: rdata_o = '0;
    endcase
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mism_o && !clr) |=> mism_o);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> mism_o);
endmodule

// File: rtl/stream_traffic_engine.sv
module stream_traffic_engine
  import tge_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter logic [LEN_W-1:0] LEN_RST = LEN_W'(64),
  localparam int NB = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [LEN_W-1:0]  reg_wdata,
  output logic [LEN_W-1:0]  reg_rdata,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [NB-1:0]     s_tkeep,
  input  logic              s_tlast,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [NB-1:0]     m_tkeep,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              mismatch
);
  ctrl_t             ctrl;
  logic [LEN_W-1:0]  gen_len;
  logic              chk_err;
  logic              accept;
  logic              gen_ready, gen_valid, gen_last;
  logic [DATA_W-1:0] gen_data;
  logic [NB-1:0]     gen_keep;

  tge_regs #(.LEN_RST(LEN_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .err_i(chk_err),
    .ctrl_o(ctrl), .len_o(gen_len), .mism_o(mismatch)
  );

  assign s_tready  = ctrl.loop_en ? m_tready : 1'b1;
  assign accept    = s_tvalid && s_tready;
  assign gen_ready = m_tready && !ctrl.loop_en;

  tge_chk #(.NB(NB)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl.chk_en), .beat_i(accept),
    .data_i(s_tdata), .keep_i(s_tkeep), .last_i(s_tlast), .err_o(chk_err)
  );

  tge_gen #(.NB(NB)) u_gen (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl.gen_en), .len_i(gen_len),
    .ready_i(gen_ready), .valid_o(gen_valid), .data_o(gen_data),
    .keep_o(gen_keep), .last_o(gen_last)
  );

  always_comb begin
    if (ctrl.loop_en) begin
      m_tvalid = s_tvalid;
      m_tdata  = s_tdata;
      m_tkeep  = s_tkeep;
      m_tlast  = s_tlast;
    end else begin
      m_tvalid = gen_valid;
      m_tdata  = gen_data;
      m_tkeep  = gen_keep;
      m_tlast  = gen_last;
    end
  end

  p_sink_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.loop_en |-> s_tready);

  p_loop_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.loop_en |-> (m_tvalid == s_tvalid && s_tready == m_tready));
endmodule

// File: tb/stream_traffic_engine_test.sv
module stream_traffic_engine_test;
  typedef struct {
    logic [127:0] data;
    logic [15:0]  keep;
    logic         last;
  } beat_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [15:0]  reg_wdata = '0;
  logic [15:0]  reg_rdata;
  logic [127:0] s_tdata = '0;
  logic [15:0]  s_tkeep = '0;
  logic         s_tlast = 1'b0;
  logic         s_tvalid = 1'b0;
  logic         s_tready;
  logic [127:0] m_tdata;
  logic [15:0]  m_tkeep;
  logic         m_tlast;
  logic         m_tvalid;
  logic         m_tready = 1'b0;
  logic         mismatch;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    mon_on = 1'b1;
  bit    done = 1'b0;
  string cur_req = "R3";
  beat_t exp_q[$];

  always #4 clk = ~clk;

  stream_traffic_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
    .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .mismatch(mismatch)
  );

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat_byte(int b, int len, int tag);
    if (b == 0) return len[7:0];
    if (b == 1) return len[15:8];
    return (b % 2 == 0) ? tag[7:0] : tag[15:8];
  endfunction

  // Expected packet for the scoreboard (R3 pattern).
  task automatic push_pkt(int len, int tag);
    int nbeats = (len + 15) / 16;
    for (int k = 0; k < nbeats; k++) begin
      beat_t bt;
      bt.data = '0;
      bt.keep = '0;
      for (int l = 0; l < 16; l++) begin
        int b = k * 16 + l;
        if (b < len) begin
          bt.keep[l] = 1'b1;
          bt.data[8*l +: 8] = pat_byte(b, len, tag & 16'hFFFF);
        end
      end
      bt.last = (k == nbeats - 1);
      exp_q.push_back(bt);
    end
  endtask

  // Scoreboard monitor: handshake seen at negedge completes at next posedge.
  always @(negedge clk) begin
    if (rst_n && mon_on && m_tvalid && m_tready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_req, " unexpected beat"}, m_tdata, '0);
      end else begin
        beat_t e;
        logic [127:0] mask;
        e = exp_q.pop_front();
        mask = '0;
        for (int l = 0; l < 16; l++) if (m_tkeep[l]) mask[8*l +: 8] = 8'hFF;
        check(m_tkeep == e.keep, {cur_req, " tkeep"}, m_tkeep, e.keep);
        check(m_tlast == e.last, {cur_req, " tlast"}, m_tlast, e.last);
        check((m_tdata & mask) == e.data, {cur_req, " tdata"}, m_tdata & mask, e.data);
      end
    end
  end

  task automatic reg_write(logic [1:0] a, logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pull_beats(int n);
    int got = 0;
    @(posedge clk); #1;
    m_tready = 1'b1;
    while (got < n) begin
      @(negedge clk);
      if (m_tvalid) got++;
    end
    @(posedge clk); #1;
    m_tready = 1'b0;
  endtask

  task automatic send_beat(logic [127:0] d, logic [15:0] k, logic l);
    @(posedge clk); #1;
    s_tdata = d; s_tkeep = k; s_tlast = l; s_tvalid = 1'b1;
    @(negedge clk);
    while (!s_tready) @(negedge clk);
    @(posedge clk); #1;
    s_tvalid = 1'b0;
  endtask

  // Checker stimulus: len_field in header, nbytes actually kept, optional corrupted byte.
  task automatic send_pkt(int len_field, int nbytes, int tag, int bad_idx);
    int nbeats = (nbytes + 15) / 16;
    for (int k = 0; k < nbeats; k++) begin
      logic [127:0] d;
      logic [15:0]  kp;
      for (int l = 0; l < 16; l++) begin
        int b = k * 16 + l;
        kp[l] = (b < nbytes);
        d[8*l +: 8] = (b < nbytes) ? pat_byte(b, len_field, tag) : 8'hA5;
        if (b == bad_idx) d[8*l +: 8] = d[8*l +: 8] ^ 8'hFF;
      end
      send_beat(d, kp, k == nbeats - 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [127:0] snap;
    logic [15:0] ksnap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    reg_read(2'd0, rd); check(rd == 16'd0, "R1 ctrl reset", rd, 0);
    reg_read(2'd1, rd); check(rd == 16'd64, "R1 len reset", rd, 64);
    reg_read(2'd2, rd); check(rd == 16'd0, "R1 status reset", rd, 0);
    check(m_tvalid == 1'b0, "R1 m_tvalid reset", m_tvalid, 0);
    check(s_tready == 1'b1, "R1 s_tready reset", s_tready, 1);
    reg_write(2'd0, 16'd5);
    reg_read(2'd0, rd); check(rd == 16'd5, "R1 ctrl readback", rd, 5);
    reg_write(2'd0, 16'd0);

    // Generator, 40-byte packets, stall then drain (R3, R5)
    cur_req = "R3";
    reg_write(2'd1, 16'd40);
    reg_read(2'd1, rd); check(rd == 16'd40, "R2 len readback", rd, 40);
    reg_write(2'd0, 16'd2);
    push_pkt(40, 0); push_pkt(40, 1);
    repeat (3) @(negedge clk);
    check(m_tvalid == 1'b1, "R5 valid while stalled", m_tvalid, 1);
    snap = m_tdata; ksnap = m_tkeep;
    repeat (3) @(negedge clk);
    check(m_tvalid && m_tdata == snap && m_tkeep == ksnap, "R5 beat stable", m_tdata, snap);
    pull_beats(6);

    // R6 length write mid-packet
    cur_req = "R6";
    push_pkt(40, 2);
    pull_beats(1);
    reg_write(2'd1, 16'd20);
    push_pkt(20, 3);
    pull_beats(4);
    // R2 length below 2
    cur_req = "R2";
    reg_write(2'd1, 16'd0);
    push_pkt(20, 4); push_pkt(2, 5);
    pull_beats(3);

    // R7 disable: presented packet completes, nothing more
    cur_req = "R7";
    reg_write(2'd0, 16'd0);
    push_pkt(2, 6);
    pull_beats(1);
    @(posedge clk); #1 m_tready = 1'b1;
    repeat (3) @(negedge clk);
    check(m_tvalid == 1'b0, "R7 no new packet", m_tvalid, 0);
    #1 m_tready = 1'b0;
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

    // R4 restart at 0 and wrap 0xFFFF -> 0
    cur_req = "R4";
    for (int i = 0; i < 65537; i++) push_pkt(2, i);
    reg_write(2'd0, 16'd2);
    pull_beats(65537);
    reg_write(2'd0, 16'd0);
    push_pkt(2, 1);
    pull_beats(1);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    // Checker
    reg_write(2'd0, 16'd1);
    @(negedge clk);
    check(s_tready == 1'b1, "R12 ready with stalled output", s_tready, 1);
    send_pkt(40, 40, 0, -1);
    reg_read(2'd2, rd); check(rd == 16'd0, "R9 clean packet", rd, 0);
    send_pkt(17, 17, 1, -1);
    reg_read(2'd2, rd); check(rd == 16'd0, "R9 unkept bytes ignored", rd, 0);
    send_pkt(40, 40, 2, 21);
    reg_read(2'd2, rd); check(rd == 16'd1, "R9 corrupted byte", rd, 1);
    check(mismatch == 1'b1, "R9 mismatch port", mismatch, 1);
    send_pkt(40, 40, 3, -1);
    reg_read(2'd2, rd); check(rd == 16'd1, "R9 sticky", rd, 1);
    reg_write(2'd2, 16'd0);
    reg_read(2'd2, rd); check(rd == 16'd1, "R11 write 0 keeps", rd, 1);
    reg_write(2'd2, 16'd1);
    reg_read(2'd2, rd); check(rd == 16'd0, "R11 write 1 clears", rd, 0);
    send_pkt(30, 32, 4, -1);
    reg_read(2'd2, rd); check(rd == 16'd1, "R10 length disagrees", rd, 1);
    reg_write(2'd2, 16'd1);
    send_pkt(16, 16, 0, -1);
    reg_read(2'd2, rd); check(rd == 16'd1, "R12 stale tag", rd, 1);
    reg_write(2'd2, 16'd1);
    // R11 set wins over same-cycle clear (expected tag now 6)
    @(posedge clk); #1;
    for (int l = 0; l < 16; l++) s_tdata[8*l +: 8] = pat_byte(l, 16, 6);
    s_tdata[8*5 +: 8] = 8'h77;
    s_tkeep = 16'hFFFF; s_tlast = 1'b1; s_tvalid = 1'b1;
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'd1;
    @(posedge clk); #1;
    s_tvalid = 1'b0; reg_wr = 1'b0;
    reg_read(2'd2, rd); check(rd == 16'd1, "R11 set beats clear", rd, 1);
    reg_write(2'd2, 16'd1);
    reg_write(2'd0, 16'd0);
    reg_write(2'd0, 16'd1);
    send_pkt(16, 16, 0, -1);
    reg_read(2'd2, rd); check(rd == 16'd0, "R12 tag reset on disable", rd, 0);

    // Loopback R8
    mon_on = 1'b0;
    reg_write(2'd0, 16'd4);
    @(negedge clk);
    check(s_tready == 1'b0, "R8 ready follows stalled output", s_tready, 0);
    @(posedge clk); #1;
    m_tready = 1'b1;
    s_tdata = {8{16'hBEEF}}; s_tkeep = 16'h00FF; s_tlast = 1'b1; s_tvalid = 1'b1;
    @(negedge clk);
    check(m_tvalid && m_tdata == {8{16'hBEEF}}, "R8 data passes", m_tdata, {8{16'hBEEF}});
    check(m_tkeep == 16'h00FF && m_tlast, "R8 keep/last pass", m_tkeep, 16'h00FF);
    check(s_tready == 1'b1, "R8 ready follows output", s_tready, 1);
    @(posedge clk); #1;
    s_tvalid = 1'b0; m_tready = 1'b0;
    reg_write(2'd0, 16'd6);
    @(posedge clk); #1 m_tready = 1'b1;
    repeat (3) @(negedge clk);
    check(m_tvalid == 1'b0, "R8 generator suppressed", m_tvalid, 0);
    #1 m_tready = 1'b0;
    cur_req = "R8";
    mon_on = 1'b1;
    reg_write(2'd0, 16'd0);
    push_pkt(2, 0);
    pull_beats(1);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R8 stalled packet resumed", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule